// File: doc/BRIEF.md
# Parity-Checked Reversible Gate Cascade

This block models a reversible circuit built from NOT, CNOT and Toffoli gates and checks it online for single line faults. The data lines enter together with their constant ancilla lines (in the default circuit, lines 1 and 2 are held at 1 by the user). The gates are applied in list order. A parity line that starts at 0 is carried through the whole cascade, and a single flag bit reports whether the parity seen at the outputs agrees with the parity seen at the inputs.

Some gates change bits on purpose, so the parity line is corrected for them. Every CNOT and Toffoli gate is an extended gate: whenever it flips its data target, it flips the parity line as well. The parity line also receives NOT operations whose count matches the parity of the number of NOT gates in the cascade. At the head of the cascade every data line is folded into the parity line, and at the tail every result line is folded in. A fault-free pass therefore leaves the parity line at 0. A single inverted line anywhere in the cascade leaves it at 1. A fault-injection selector can invert any one line, the parity line included, right after any one gate.

One vector is accepted per cycle. The result vector and the flag are registered and appear one cycle after the input is accepted.

Top module: `pcc_cascade`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid`, `res_o` and `flag_o` are 0 until the first vector is accepted.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `out_valid` is low, `res_o` and `flag_o` keep their previous values.
- R3: With no fault injected, `res_o` is the input vector after each gate is applied in list order. NOT inverts its target. CNOT XORs its control into its target. Toffoli XORs the AND of its two controls into its target. Each gate word is {kind[13:12], control A[11:8], control B[7:4], target[3:0]}, where kind is 0 for NOT, 1 for CNOT and 2 for Toffoli.
- R4: With `fault_en` low, `flag_o` is 0 for every input vector, including vectors whose ancilla lines are not at their nominal values.
- R5: With `fault_en` high, `fault_gate` below the gate count and `fault_line` naming a data line, `flag_o` is 1 for every input vector and every such location.
- R6: `fault_line` equal to the line count selects the parity line. An injected fault there sets `flag_o` to 1 and leaves `res_o` equal to the fault-free result.
- R7: An injected data-line fault inverts that line right after gate `fault_gate`, before the next gate acts. Later gates then propagate the inverted value.
- R8: With `fault_en` low, the values on `fault_gate` and `fault_line` have no effect on `res_o` or `flag_o`.
- R9: A selector out of range (`fault_gate` at or above the gate count, or `fault_line` above the line count) injects nothing: `res_o` is the fault-free result and `flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `data_i` this cycle |
| data_i | input | N_LINES | Data and ancilla line values |
| fault_en | input | 1 | Enable fault injection |
| fault_gate | input | GSEL_W | Index of the gate after which the fault is applied |
| fault_line | input | LSEL_W | Line to invert; N_LINES selects the parity line |
| out_valid | output | 1 | Result and flag are new this cycle |
| res_o | output | N_LINES | Cascade result vector |
| flag_o | output | 1 | 1 when a line fault was detected |

## Verification
A wrong target mask or a wrong gate order shows in `res_o` one cycle after the affected vector is accepted. A missing parity mirror on an extended gate, a wrong NOT balance, or a dropped fold at either end sets `flag_o` on clean vectors in that same cycle. A tap that inverts the wrong line or fires after the wrong gate changes `res_o` for some vector in the sweep over every gate, every line and every vector. A tap that fails to fire leaves `flag_o` at 0 where 1 is expected.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   localparam int IDX_W = 4;
   localparam int GW    = 2 + 3 * IDX_W;

   typedef enum logic [1:0] {
      K_NOT  = 2'd0,
      K_CNOT = 2'd1,
      K_TOF  = 2'd2
   } kind_e;

   typedef logic [GW-1:0] gate_w_t;

   function automatic gate_w_t mk_gate(kind_e k, int a, int b, int t);
      return {k, IDX_W'(a), IDX_W'(b), IDX_W'(t)};
   endfunction
endpackage

// File: rtl/pcc_gate_stage.sv
module pcc_gate_stage
   import pcc_pkg::*;
#(
   parameter int      N_LINES     = 5,
   parameter gate_w_t GATE        = '0,
   parameter bit      NOT_AT_GATE = 1'b0
) (
   input  logic [N_LINES:0] d_i,
   output logic [N_LINES:0] d_o
);
   localparam logic [1:0] KIND = GATE[GW-1 -: 2];
   localparam int CA  = int'(GATE[3*IDX_W-1 -: IDX_W]);
   localparam int CB  = int'(GATE[2*IDX_W-1 -: IDX_W]);
   localparam int TGT = int'(GATE[IDX_W-1:0]);
   localparam int PL  = N_LINES;

   if (TGT >= N_LINES || CA >= N_LINES || CB >= N_LINES) begin : g_bad_idx
      $error("gate index out of range");
   end
   if (KIND != K_NOT && CA == TGT) begin : g_bad_ctl
      $error("control equals target");
   end

   if (KIND == K_NOT) begin : g_not
      always_comb begin
         d_o      = d_i;
         d_o[TGT] = ~d_i[TGT];
         if (NOT_AT_GATE) d_o[PL] = ~d_i[PL];
      end
   end else if (KIND == K_CNOT) begin : g_cnot
      logic fire;
      assign fire = d_i[CA];
      always_comb begin
         d_o      = d_i;
         d_o[TGT] = d_i[TGT] ^ fire;
         d_o[PL]  = d_i[PL] ^ fire;
      end
   end else if (KIND == K_TOF) begin : g_tof
      logic fire;
      assign fire = d_i[CA] & d_i[CB];
      always_comb begin
         d_o      = d_i;
         d_o[TGT] = d_i[TGT] ^ fire;
         d_o[PL]  = d_i[PL] ^ fire;
      end
   end else begin : g_bad_kind
      $error("unknown gate kind");
      assign d_o = d_i;
   end

   // R3
   always_comb begin
      gate_flip_chk: assert ($countones(d_i[N_LINES-1:0] ^ d_o[N_LINES-1:0]) <= 1)
         else $error("gate changed more than one data line");
   end
endmodule

// File: rtl/pcc_fault_tap.sv
module pcc_fault_tap #(
   parameter int N_LINES  = 5,
   parameter int GATE_IDX = 0,
   parameter int GSEL_W   = 4,
   parameter int LSEL_W   = 4
) (
   input  logic              en,
   input  logic [GSEL_W-1:0] gate_sel,
   input  logic [LSEL_W-1:0] line_sel,
   input  logic [N_LINES:0]  d_i,
   output logic [N_LINES:0]  d_o
);
   logic              hit;
   logic [N_LINES:0]  mask;

   assign hit = en && (gate_sel == GSEL_W'(GATE_IDX));

   always_comb begin
      for (int i = 0; i <= N_LINES; i++) begin
         mask[i] = hit && (line_sel == LSEL_W'(i));
      end
   end

   assign d_o = d_i ^ mask;

   // R5
   always_comb begin
      tap_single_chk: assert ($countones(d_i ^ d_o) <= 1)
         else $error("fault tap inverted more than one line");
   end
endmodule

// File: rtl/pcc_parity_close.sv
module pcc_parity_close #(
   parameter int N_LINES = 5,
   parameter bit BAL     = 1'b0
) (
   input  logic [N_LINES:0] d_i,
   output logic             flag
);
   assign flag = d_i[N_LINES] ^ BAL ^ (^d_i[N_LINES-1:0]);
endmodule

// File: rtl/pcc_cascade.sv
module pcc_cascade
   import pcc_pkg::*;
#(
   parameter int      N_LINES     = 5,
   parameter int      N_GATES     = 7,
   parameter bit      NOT_AT_GATE = 1'b0,
   parameter gate_w_t GATE_LIST [N_GATES] = '{
      mk_gate(K_TOF,  0, 3, 1),
      mk_gate(K_NOT,  0, 0, 0),
      mk_gate(K_CNOT, 4, 4, 2),
      mk_gate(K_TOF,  0, 4, 3),
      mk_gate(K_NOT,  0, 0, 4),
      mk_gate(K_TOF,  1, 2, 0),
      mk_gate(K_NOT,  0, 0, 2)
   },
   localparam int GSEL_W = $clog2(N_GATES) + 1,
   localparam int LSEL_W = $clog2(N_LINES + 1) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [N_LINES-1:0] data_i,
   input  logic               fault_en,
   input  logic [GSEL_W-1:0]  fault_gate,
   input  logic [LSEL_W-1:0]  fault_line,
   output logic               out_valid,
   output logic [N_LINES-1:0] res_o,
   output logic               flag_o
);
   if (N_LINES < 2 || N_LINES >= (1 << IDX_W)) begin : g_bad_lines
      $error("N_LINES out of supported range");
   end
   if (N_GATES < 1) begin : g_bad_gates
      $error("N_GATES must be positive");
   end

   function automatic bit not_parity();
      bit p = 1'b0;
      for (int i = 0; i < N_GATES; i++) begin
         if (GATE_LIST[i][GW-1 -: 2] == K_NOT) p = ~p;
      end
      return p;
   endfunction

   localparam bit END_BAL = NOT_AT_GATE ? 1'b0 : not_parity();

   logic [N_LINES:0] chain [N_GATES+1];
   logic             flag_c;

   assign chain[0] = {^data_i, data_i};

   for (genvar g = 0; g < N_GATES; g++) begin : g_stage
      logic [N_LINES:0] mid;
      pcc_gate_stage #(
         .N_LINES    (N_LINES),
         .GATE       (GATE_LIST[g]),
         .NOT_AT_GATE(NOT_AT_GATE)
      ) u_gate (
         .d_i(chain[g]),
         .d_o(mid)
      );
      pcc_fault_tap #(
         .N_LINES (N_LINES),
         .GATE_IDX(g),
         .GSEL_W  (GSEL_W),
         .LSEL_W  (LSEL_W)
      ) u_tap (
         .en      (fault_en),
         .gate_sel(fault_gate),
         .line_sel(fault_line),
         .d_i     (mid),
         .d_o     (chain[g+1])
      );
   end

   pcc_parity_close #(
      .N_LINES(N_LINES),
      .BAL    (END_BAL)
   ) u_close (
      .d_i (chain[N_GATES]),
      .flag(flag_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_o     <= '0;
         flag_o    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res_o  <= chain[N_GATES][N_LINES-1:0];
            flag_o <= flag_c;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(res_o) && $stable(flag_o)));
   // R4
   clean_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fault_en) |=> !flag_o);
   // R5
   fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fault_en && (int'(fault_gate) < N_GATES)
       && (int'(fault_line) <= N_LINES)) |=> flag_o);
endmodule

// File: tb/pcc_cascade_test.sv
module pcc_cascade_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [4:0] data_i = '0;
   logic       fault_en = 1'b0;
   logic [3:0] fault_gate = '0;
   logic [3:0] fault_line = '0;
   logic       out_valid;
   logic [4:0] res_o;
   logic       flag_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [4:0] res;
      logic       flag;
      string      rtag;
      string      ftag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   pcc_cascade uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_i(data_i),
      .fault_en(fault_en), .fault_gate(fault_gate), .fault_line(fault_line),
      .out_valid(out_valid), .res_o(res_o), .flag_o(flag_o)
   );

   // Default circuit written out gate by gate from the requirements.
   function automatic void golden(input logic [4:0] v, input logic fe,
                                  input int fg, input int fl,
                                  output logic [4:0] r, output logic f);
      logic [4:0] s;
      s = v;
      for (int k = 0; k < 7; k++) begin
         case (k)
            0: s[1] = s[1] ^ (s[0] & s[3]);
            1: s[0] = ~s[0];
            2: s[2] = s[2] ^ s[4];
            3: s[3] = s[3] ^ (s[0] & s[4]);
            4: s[4] = ~s[4];
            5: s[0] = s[0] ^ (s[1] & s[2]);
            default: s[2] = ~s[2];
         endcase
         if (fe && fg == k && fl < 5) s[fl] = ~s[fl];
      end
      r = s;
      f = fe && (fg < 7) && (fl <= 5);
   endfunction

   task automatic check(input string req, input int got, input int want);
      total++;
      if (got != want) begin
         bad++;
         $display("FAIL %s got=%0h expected=%0h", req, got, want);
      end
   endtask

   task automatic send(input logic [4:0] v, input logic fe, input int fg, input int fl);
      exp_t e;
      logic [4:0] r;
      logic f;
      @(negedge clk);
      in_valid   = 1'b1;
      data_i     = v;
      fault_en   = fe;
      fault_gate = 4'(fg);
      fault_line = 4'(fl);
      golden(v, fe, fg, fl, r, f);
      e.res  = r;
      e.flag = f;
      if (!fe) begin
         e.rtag = (fg != 0 || fl != 0) ? "R8" : "R3";
         e.ftag = (fg != 0 || fl != 0) ? "R8" : "R4";
      end else if (fg >= 7 || fl > 5) begin
         e.rtag = "R9";
         e.ftag = "R9";
      end else if (fl == 5) begin
         e.rtag = "R6";
         e.ftag = "R6";
      end else begin
         e.rtag = "R7";
         e.ftag = "R5";
      end
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid   = 1'b0;
         data_i     = 5'h1f;
         fault_en   = 1'b1;
         fault_gate = 4'd3;
      end
   endtask

   // Monitor: pops one expected item per valid output.
   logic [4:0] last_res = '0;
   logic       last_flag = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R2", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.rtag, int'(res_o), int'(e.res));
               check(e.ftag, int'(flag_o), int'(e.flag));
            end
         end else begin
            // R2: outputs hold while no result is produced
            check("R2", int'({res_o, flag_o}), int'({last_res, last_flag}));
         end
         last_res  = res_o;
         last_flag = flag_o;
      end
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog got=%0d expected=<%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", int'({out_valid, res_o, flag_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'({out_valid, res_o, flag_o}), 0);

      for (int v = 0; v < 32; v++) begin
         send(5'(v), 1'b0, 0, 0);
         send(5'(v), 1'b0, 3, 2);
         send(5'(v), 1'b0, 6, 5);
         for (int g = 0; g < 7; g++) begin
            for (int l = 0; l < 6; l++) begin
               send(5'(v), 1'b1, g, l);
            end
         end
         send(5'(v), 1'b1, 9, 1);
         send(5'(v), 1'b1, 2, 7);
         if (v % 8 == 7) idle(3);
      end
      idle(4);
      // R2: every accepted vector produced exactly one result
      check("R2", exp_q.size(), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule